// File: doc/BRIEF.md
# Streaming two-way merge stage

This block is one stage of a pipelined merge sorter that handles one element per clock. Stage `LEVEL` receives a stream made of sorted runs, each `2^(LEVEL-1)` elements long. Every run start is flagged. The runs are taken in pairs. The first run of a pair is held in a small register queue. When the first element of the second run arrives, a control unit begins merging the two runs. It remembers how many elements of each run it has already sent out and uses that count to steer two selectors: one picks the head of each queue, the other picks which head goes to the output. The result is one sorted run of `2^LEVEL` elements, again flagged at its start. Chaining `log2(N)` stages with `LEVEL` = 1, 2, … gives a full sorter for N elements. The stages differ only in the depth of their queues.

Each element is `DATA_W` bits wide. Only the upper `KEY_W` bits are compared, and the lower bits are payload that rides along untouched. When two keys are equal, the element from the first run of the pair goes out first, so the merge is stable. Across a chain of stages this makes the whole sort stable.

Top module: `merge_stage`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a pair of runs has begun to merge.
- R2: Within each output run, the keys (`out_data[DATA_W-1 -: KEY_W]`) never decrease.
- R3: Each output run of `2^LEVEL` elements holds exactly the elements of one input pair: the first run followed in the stream by the second run. Every element appears once, with all its bits unchanged.
- R4: When a key in the first run equals a key in the second run, the element from the first run is emitted first.
- R5: When one run of a pair has been fully emitted, the remaining elements of the other run are emitted in their arrival order.
- R6: No element of a pair is emitted before the first element of its second run has been accepted. The first output of a pair is valid at the second rising edge after the edge that accepted that element.
- R7: When input pairs arrive back to back with `in_valid` held high, the stage emits one element every clock, with no idle cycle between output runs.
- R8: `out_first` is high on the first element of each output run and on no other element, so that markers are exactly `2^LEVEL` outputs apart.
- R9: Input runs are paired by the `in_first` marker of accepted elements: the first run after reset is a first run, and after that roles alternate. Idle cycles (`in_valid` low) change neither the pairing nor the result.
- R10: Only the upper `KEY_W` bits take part in the comparison. The lower `DATA_W-KEY_W` payload bits do not affect the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input element is present this cycle |
| in_first | input | 1 | The input element starts a new run |
| in_data | input | DATA_W | Input element: key in the upper KEY_W bits, payload below |
| out_valid | output | 1 | An output element is present this cycle |
| out_first | output | 1 | The output element starts a merged run |
| out_data | output | DATA_W | Output element |

## Verification
The bench targets the cases where the merge order is easy to get wrong:
- Interleaved keys. A design that compared the wrong heads or swapped the selector polarity would emit out of order.
- One run entirely below the other. A design that kept comparing after a run was exhausted would fetch from an empty queue or run ahead into the next pair's elements.
- Equal keys whose payloads are ordered the opposite way. A design that compared all data bits, or broke ties toward the second run, would put the second run's element first.
- Back-to-back pairs, with contiguous output and first-marker spacing checked. A design that lost throughput at a pair boundary would show an idle cycle, or misplace `out_first`.
- Gapped input, with the latency of the first output also checked. A design that paired runs by cycle count rather than by markers would scramble the pairs, and one that merged early would emit before the second run existed.

// File: rtl/merge_stage_pkg.sv
package merge_stage_pkg;
  typedef enum logic {
    RUN_LEAD  = 1'b0,
    RUN_TRAIL = 1'b1
  } run_role_e;

  function automatic int unsigned run_len(input int unsigned level);
    return 32'd1 << (level - 1);
  endfunction
endpackage

// File: rtl/merge_stage_fifo.sv
module merge_stage_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         not_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_data;
  end

  assign head      = mem[rd_ptr_q];
  assign not_empty = (cnt_q != '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (int'(cnt_q) < DEPTH));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/merge_stage_ctrl.sv
module merge_stage_ctrl #(
  parameter int DATA_W  = 8,
  parameter int KEY_W   = 4,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] lead_head,
  input  logic              lead_ne,
  input  logic [DATA_W-1:0] trail_head,
  input  logic              trail_ne,
  output logic              pop_lead,
  output logic              pop_trail,
  output logic              emit,
  output logic              emit_first,
  output logic [DATA_W-1:0] emit_data
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(RUN_LEN);

  logic [CW-1:0] lead_used_q, lead_used_d, trail_used_q, trail_used_d;
  logic [CW-1:0] lead_inc, trail_inc;
  logic          lead_done, trail_done, lead_av, trail_av, lead_wins, pair_end;
  logic [KEY_W-1:0] lead_key, trail_key;

  always_comb begin
    lead_key   = lead_head[DATA_W-1 -: KEY_W];
    trail_key  = trail_head[DATA_W-1 -: KEY_W];
    lead_done  = (lead_used_q == LEN_C);
    trail_done = (trail_used_q == LEN_C);
    lead_av    = lead_ne && !lead_done;
    trail_av   = trail_ne && !trail_done;
    lead_wins  = (lead_key <= trail_key);
    pop_lead   = lead_av && (trail_done || (trail_av && lead_wins));
    pop_trail  = trail_av && (lead_done || (lead_av && !lead_wins));
    emit       = pop_lead || pop_trail;
    emit_first = emit && (lead_used_q == '0) && (trail_used_q == '0);
    emit_data  = pop_lead ? lead_head : trail_head;
    lead_inc   = lead_used_q + CW'(pop_lead);
    trail_inc  = trail_used_q + CW'(pop_trail);
    pair_end   = (lead_inc == LEN_C) && (trail_inc == LEN_C);
    lead_used_d  = pair_end ? '0 : lead_inc;
    trail_used_d = pair_end ? '0 : trail_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_used_q  <= '0;
      trail_used_q <= '0;
    end else if (emit) begin
      lead_used_q  <= lead_used_d;
      trail_used_q <= trail_used_d;
    end
  end

  // R3
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_lead, pop_trail}));

  // R6
  wait_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_used_q == '0 && !trail_ne) |-> !emit);
endmodule

// File: rtl/merge_stage.sv
module merge_stage
  import merge_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEY_W  = 4,
  parameter int LEVEL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_first,
  output logic [DATA_W-1:0] out_data
);
  localparam int RUN_LEN = int'(run_len(LEVEL));
  localparam int DEPTH   = RUN_LEN + 1;
  localparam int OUT_LEN = 2 * RUN_LEN;
  localparam int RCW     = $clog2(OUT_LEN + 1);

  run_role_e role_q, role_d, beat_role;
  logic push_lead, push_trail;
  logic [DATA_W-1:0] lead_head, trail_head, emit_data;
  logic lead_ne, trail_ne, pop_lead, pop_trail, emit, emit_first;
  logic              vld_q, first_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    beat_role  = in_first ? ((role_q == RUN_LEAD) ? RUN_TRAIL : RUN_LEAD) : role_q;
    role_d     = (in_valid && in_first) ? beat_role : role_q;
    push_lead  = in_valid && (beat_role == RUN_LEAD);
    push_trail = in_valid && (beat_role == RUN_TRAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) role_q <= RUN_TRAIL;
    else        role_q <= role_d;
  end

  merge_stage_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_lead_q (
    .clk(clk), .rst_n(rst_n), .push(push_lead), .push_data(in_data),
    .pop(pop_lead), .head(lead_head), .not_empty(lead_ne));

  merge_stage_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_trail_q (
    .clk(clk), .rst_n(rst_n), .push(push_trail), .push_data(in_data),
    .pop(pop_trail), .head(trail_head), .not_empty(trail_ne));

  merge_stage_ctrl #(.DATA_W(DATA_W), .KEY_W(KEY_W), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lead_head(lead_head), .lead_ne(lead_ne),
    .trail_head(trail_head), .trail_ne(trail_ne),
    .pop_lead(pop_lead), .pop_trail(pop_trail),
    .emit(emit), .emit_first(emit_first), .emit_data(emit_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      vld_q   <= emit;
      first_q <= emit_first;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) data_q <= emit_data;
  end

  assign out_valid = vld_q;
  assign out_first = first_q;
  assign out_data  = data_q;

  logic [KEY_W-1:0] last_key_q;
  logic [RCW-1:0]   run_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_key_q <= '0;
      run_cnt_q  <= '0;
    end else if (out_valid) begin
      last_key_q <= out_data[DATA_W-1 -: KEY_W];
      run_cnt_q  <= out_first ? RCW'(1) : run_cnt_q + 1'b1;
    end
  end

  // R2
  sorted_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> (out_data[DATA_W-1 -: KEY_W] >= last_key_q));

  // R8
  marker_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> (run_cnt_q == '0 || run_cnt_q == RCW'(OUT_LEN)));

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> (run_cnt_q != '0 && run_cnt_q < RCW'(OUT_LEN)));

  // R1
  first_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
endmodule

// File: tb/merge_stage_tb.sv
module merge_stage_tb;
  localparam int DW = 8;
  localparam int KW = 4;
  localparam int LV = 3;
  localparam int R  = 4;
  localparam int P  = 2 * R;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_first;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  merge_stage #(.DATA_W(DW), .KEY_W(KW), .LEVEL(LV)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .out_valid(out_valid), .out_first(out_first),
    .out_data(out_data));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] cap_data [256];
  logic          cap_first [256];
  int            cap_cyc [256];
  int            cap_n = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 256) begin
      cap_data[cap_n]  = out_data;
      cap_first[cap_n] = out_first;
      cap_cyc[cap_n]   = cyc;
      cap_n = cap_n + 1;
    end
  end

  int checks = 0, failures = 0;
  logic [DW-1:0] src [64];
  logic [DW-1:0] exp_d [64];
  int b0_cyc;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build_expected(input int npairs);
    for (int p = 0; p < npairs; p++) begin
      int ia = 0, ib = 0;
      for (int k = 0; k < P; k++) begin
        logic [DW-1:0] a, b;
        bit take_a;
        a = src[p*P + ia];
        b = src[p*P + R + ib];
        if (ia == R) take_a = 0;
        else if (ib == R) take_a = 1;
        else take_a = (a[DW-1 -: KW] <= b[DW-1 -: KW]);
        if (take_a) begin exp_d[p*P+k] = a; ia++; end
        else begin exp_d[p*P+k] = b; ib++; end
      end
    end
  endtask

  task automatic feed(input int npairs, input bit gaps);
    for (int i = 0; i < npairs*P; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = src[i];
      in_first = (i % R == 0);
      if (i == R) b0_cyc = cyc;
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b1;
        in_data  = '1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    repeat (3*P) @(negedge clk);
  endtask

  task automatic run_case(input string name, input int npairs, input bit gaps,
                          input bit chk_cont);
    int base, n;
    base = cap_n;
    n = npairs * P;
    build_expected(npairs);
    feed(npairs, gaps);
    check(cap_n - base == n, {name, " R3 count"}, cap_n - base, n);
    for (int i = 0; i < n && base + i < cap_n; i++) begin
      check(cap_data[base+i] == exp_d[i], {name, " R2 R3 data"},
            int'(cap_data[base+i]), int'(exp_d[i]));
      check(cap_first[base+i] == (i % P == 0), {name, " R8 marker"},
            int'(cap_first[base+i]), int'(i % P == 0));
      if (chk_cont && i > 0)
        check(cap_cyc[base+i] == cap_cyc[base+i-1] + 1, {name, " R7 contiguous"},
              cap_cyc[base+i], cap_cyc[base+i-1] + 1);
    end
    if (!gaps && cap_n > base)
      check(cap_cyc[base] == b0_cyc + 2, {name, " R6 latency"}, cap_cyc[base], b0_cyc + 2);
  endtask

  task automatic t_reset();
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
    end
  endtask

  task automatic t_interleave();
    for (int i = 0; i < R; i++) begin
      src[i]   = {4'(2*i+1), 4'(i)};
      src[R+i] = {4'(2*i+2), 4'(8+i)};
    end
    run_case("interleave", 1, 0, 1);
  endtask

  task automatic t_lead_low();
    for (int i = 0; i < R; i++) begin
      src[i]   = {4'(1+i), 4'(i)};
      src[R+i] = {4'(9+i), 4'(i)};
    end
    run_case("R5 lead_low", 1, 0, 1);
  endtask

  task automatic t_trail_low();
    for (int i = 0; i < R; i++) begin
      src[i]   = {4'(10+i), 4'(i)};
      src[R+i] = {4'(2+i), 4'(i)};
    end
    run_case("R5 trail_low", 1, 0, 1);
  endtask

  task automatic t_ties();
    for (int i = 0; i < R; i++) begin
      src[i]   = {4'd6, 4'(12+i)};
      src[R+i] = {4'd6, 4'(i)};
    end
    run_case("R4 R10 ties", 1, 0, 1);
    for (int i = 0; i < R; i++)
      check(cap_data[cap_n-P+i][3:0] == 4'(12+i), "R4 R10 lead first on tie",
            int'(cap_data[cap_n-P+i][3:0]), 12+i);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 3*P; i++)
      src[i] = {4'((i*7 + 3) % 16), 4'(i % 16)};
    for (int p = 0; p < 6; p++)
      for (int a = 0; a < R; a++)
        for (int b = 0; b < R-1-a; b++)
          if (src[p*R+b][7:4] > src[p*R+b+1][7:4]) begin
            logic [DW-1:0] t;
            t = src[p*R+b]; src[p*R+b] = src[p*R+b+1]; src[p*R+b+1] = t;
          end
    run_case("R7 stream", 3, 0, 1);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 2*P; i++)
      src[i] = {4'((i % R) * 3 + (i / R) % 2), 4'(i)};
    run_case("R9 gaps", 2, 1, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_interleave();
    t_lead_low();
    t_trail_low();
    t_ties();
    t_stream();
    t_gaps();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule